// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Port-Controlled Line Override

This block sends bytes over an asynchronous serial line. Bytes written into a small transmit FIFO are sent one per frame: a low start bit, eight data bits least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen strobes of an externally generated 16x base tick. A transmit-end output reports when the line has no frame in progress and no byte is waiting.

While the transmit enable is low, the transmitter does not drive the pin. The pin's output enable and level come from two port-control bits, a direction bit and a data bit. Both bits are loaded by a write strobe and reset to 1, so the line idles at mark. Clearing the enable aborts any frame at once, even mid-bit, and flushes the FIFO. Software sends a break by clearing the port data bit and then the enable, so no separate break state is needed.

Top module: `ser_tx_top`

## Requirements
- R1: While `tx_en_i` is low, `txd_oe_o` equals the stored port direction bit and `txd_o` equals the stored port data bit. Both bits are loaded from `port_dir_i`/`port_dat_i` on a clock edge where `port_we_i` is high.
- R2: After reset both port bits are 1, so `txd_o`=1, `txd_oe_o`=1 and `tx_end_o`=1.
- R3: When `tx_en_i` goes low mid-frame, the pin follows the port bits in that same cycle, and the frame in progress is discarded.
- R4: After the port data bit is cleared and then `tx_en_i` is cleared, `txd_o` is 0 (a break) for as long as both stay so.
- R5: A frame starts with a 0 start bit and then sends the 8 data bits LSB first. Each bit holds for 16 `tick_i` strobes, and the line changes only on clock edges where `tick_i` is high.
- R6: With `par_en_i`=1, a parity bit follows bit 7. It is even parity when `par_odd_i`=0 and odd parity when `par_odd_i`=1.
- R7: Stop bits are 1. There is one stop bit when `stop2_i`=0 and two when `stop2_i`=1. The format inputs are sampled when a frame starts.
- R8: Clearing `tx_en_i` empties the FIFO: `wr_full_o` drops, `tx_end_o` is 1, and on re-enable nothing queued before is sent.
- R9: When enabled with an empty FIFO and no frame in progress, `txd_o`=1, `txd_oe_o`=1 and `tx_end_o`=1. A byte written then starts its start bit on the next tick edge.
- R10: A write while `tx_en_i` is low is ignored, and no frame follows on enable.
- R11: The FIFO holds DEPTH bytes. `wr_full_o` is 1 when it is full, and a write while full is dropped. Queued bytes are sent back to back with no idle gap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x base tick strobe |
| wr_i | input | 1 | FIFO write strobe |
| wr_data_i | input | 8 | Byte to queue |
| wr_full_o | output | 1 | FIFO full |
| tx_en_i | input | 1 | Transmit enable |
| port_we_i | input | 1 | Load port-control bits |
| port_dir_i | input | 1 | New port direction bit (1 = drive) |
| port_dat_i | input | 1 | New port data bit |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity select |
| stop2_i | input | 1 | Two stop bits |
| txd_o | output | 1 | Serial line level |
| txd_oe_o | output | 1 | Serial line output enable |
| tx_end_o | output | 1 | No frame in progress and FIFO empty |

## Verification
A write, a port-bit load and a tick all take effect at the clock edge where they are sampled. So the FIFO count, the port bits and the line level are due one edge later, while the enable acts on the pin in the same cycle through the output path. The bench runs a behavioural model in step with the clock, using a byte queue and a queue of the remaining frame bits. It compares all four outputs two time units after every rising edge, once the edge's register updates and the inputs set at the previous falling edge have settled. Scenario checks at chosen points then confirm aborts, breaks, drops and the reset state.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OVS    = 16;
  localparam int unsigned FRAME_W = DATA_W + 4; // start, data, parity, two stops
endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = en_i && push_i && !full_o;
  assign do_pop  = en_i && pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> empty_o);
  assert_full_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && full_o && push_i && !pop_i) |=> full_o);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BL_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q, frame_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [BL_W-1:0]    left_q, nbits_d;
  logic               busy_q, bit_end, last_bit, load;

  always_comb begin
    frame_d = '1;
    frame_d[0] = 1'b0;
    frame_d[DATA_W:1] = data_i;
    if (par_en_i) frame_d[DATA_W+1] = par_odd_i ^ (^data_i);
    nbits_d = BL_W'(DATA_W + 2) + BL_W'(par_en_i) + BL_W'(stop2_i);
  end

  assign bit_end  = busy_q && tick_i && (cnt_q == CNT_W'(OVS - 1));
  assign last_bit = bit_end && (left_q == BL_W'(1));
  assign load     = en_i && tick_i && !empty_i && (!busy_q || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (!en_i) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= frame_d;
      left_q  <= nbits_d;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (bit_end) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
      cnt_q   <= '0;
      if (last_bit) busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pop_o  = load;
  assign busy_o = busy_q;
  assign line_o = shreg_q[0];

  assert_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_q && shreg_q[0]));
  assert_start_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !shreg_q[0]);
  assert_tick_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(shreg_q[0]));
  assert_left_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0));
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       wr_full_o,
  input  logic       tx_en_i,
  input  logic       port_we_i,
  input  logic       port_dir_i,
  input  logic       port_dat_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       stop2_i,
  output logic       txd_o,
  output logic       txd_oe_o,
  output logic       tx_end_o
);
  logic       port_dir_q, port_dat_q;
  logic       empty, pop, busy, line;
  logic [7:0] head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_dir_q <= 1'b1;
      port_dat_q <= 1'b1;
    end else if (port_we_i) begin
      port_dir_q <= port_dir_i;
      port_dat_q <= port_dat_i;
    end
  end

  ser_tx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i, .rst_ni, .en_i(tx_en_i), .push_i(wr_i), .data_i(wr_data_i),
    .pop_i(pop), .data_o(head), .empty_o(empty), .full_o(wr_full_o)
  );

  ser_tx_shift u_shift (
    .clk_i, .rst_ni, .en_i(tx_en_i), .tick_i, .empty_i(empty), .data_i(head),
    .par_en_i, .par_odd_i, .stop2_i, .pop_o(pop), .busy_o(busy), .line_o(line)
  );

  // enable hands the pin to the port bits combinationally
  assign txd_o    = tx_en_i ? line : port_dat_q;
  assign txd_oe_o = tx_en_i ? 1'b1 : port_dir_q;
  assign tx_end_o = !tx_en_i || (!busy && empty);

  assert_end_mark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && tx_end_o) |-> txd_o);
  assert_end_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> !wr_full_o || !tx_en_i);
endmodule

// File: tb/ser_tx_top_test.sv
`timescale 1ns/1ps
module ser_tx_top_test;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, tx_en = 1'b0, port_we = 1'b0, pdir = 1'b1, pdat = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic [7:0] wdata = '0;
  logic txd, txd_oe, tx_end, full;

  int n_tests = 0, n_fail = 0, cyc = 0, tdiv = 0;
  string phase = "R2";

  always #5 clk = ~clk;

  ser_tx_top #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .wr_full_o(full), .tx_en_i(tx_en), .port_we_i(port_we), .port_dir_i(pdir),
    .port_dat_i(pdat), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .txd_o(txd), .txd_oe_o(txd_oe), .tx_end_o(tx_end)
  );

  // behavioural reference
  logic [7:0] m_q[$];
  bit m_bits[$];
  bit m_busy = 0, m_dir = 1, m_dat = 1;
  int m_cnt = 0;

  task automatic m_load();
    logic [7:0] d;
    d = m_q.pop_front();
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(d[i]);
    if (par_en) m_bits.push_back(par_odd ^ (^d));
    m_bits.push_back(1'b1);
    if (stop2) m_bits.push_back(1'b1);
    m_busy = 1; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    int old;
    if (!rst_n) begin
      m_q.delete(); m_bits.delete(); m_busy = 0; m_cnt = 0; m_dir = 1; m_dat = 1;
    end else begin
      old = m_q.size();
      if (!tx_en) begin
        m_q.delete(); m_bits.delete(); m_busy = 0; m_cnt = 0;
      end else begin
        if (tick) begin
          if (m_busy) begin
            if (m_cnt == 15) begin
              m_cnt = 0;
              void'(m_bits.pop_front());
              if (m_bits.size() == 0) begin
                m_busy = 0;
                if (old > 0) m_load();
              end
            end else m_cnt++;
          end else if (old > 0) m_load();
        end
        if (wr && old < DEPTH) m_q.push_back(wdata);
      end
      if (port_we) begin m_dir = pdir; m_dat = pdat; end
    end
  end

  function automatic logic [3:0] m_out();
    logic l;
    l = m_busy ? m_bits[0] : 1'b1;
    return {tx_en ? l : m_dat, tx_en ? 1'b1 : m_dir,
            !tx_en || (!m_busy && m_q.size() == 0), m_q.size() == DEPTH};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison away from the edge
  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst_n) chk(phase, {4'b0, txd, txd_oe, tx_end, full}, {4'b0, m_out()});
  end

  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 0);
  end

  task automatic done();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic put(logic [7:0] b);
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
  endtask
  task automatic setport(logic d, logic v);
    @(negedge clk); port_we = 1; pdir = d; pdat = v;
    @(negedge clk); port_we = 0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (m_busy || m_q.size() != 0);
    cycles(4);
  endtask

  initial begin
    cycles(3);
    #1 chk("R2 reset", {5'b0, txd, txd_oe, tx_end}, 8'h07);
    rst_n = 1;
    cycles(2);
    chk("R2 idle", {5'b0, txd, txd_oe, tx_end}, 8'h07);

    phase = "R1";
    setport(1'b0, 1'b0); cycles(1);
    chk("R1 port", {6'b0, txd, txd_oe}, 8'h00);
    setport(1'b1, 1'b0); cycles(1);
    chk("R1 port", {6'b0, txd, txd_oe}, 8'h01);
    setport(1'b1, 1'b1);

    phase = "R10";
    put(8'h3C);
    @(negedge clk); tx_en = 1;
    cycles(20);
    chk("R10 ignored", {6'b0, txd, tx_end}, 8'h03);

    phase = "R9";
    put(8'hA5);
    cycles(3);
    chk("R9 started", {7'b0, tx_end}, 8'h00);
    phase = "R5"; wait_idle();

    phase = "R6"; par_en = 1; par_odd = 0; put(8'h07); wait_idle();
    par_odd = 1; put(8'h07); wait_idle();
    put(8'hFF); wait_idle();

    phase = "R7"; par_en = 0; stop2 = 1; put(8'h81); wait_idle();
    stop2 = 0;

    phase = "R11";
    @(negedge clk); wr = 1;
    for (int i = 0; i < 6; i++) begin wdata = 8'h10 + 8'(i); @(negedge clk); end
    wr = 0;
    cycles(1);
    chk("R11 full", {7'b0, full}, 8'h01);
    wait_idle();

    phase = "R3";
    put(8'h55); put(8'hF0);
    cycles(100);
    setport(1'b1, 1'b0);
    @(negedge clk); tx_en = 0;
    #1 chk("R3 abort", {6'b0, txd, txd_oe}, 8'h01);
    phase = "R4";
    cycles(60);
    chk("R4 break", {6'b0, txd, tx_end}, 8'h01);
    phase = "R8";
    chk("R8 flushed", {7'b0, full}, 8'h00);
    setport(1'b1, 1'b1);
    @(negedge clk); tx_en = 1;
    cycles(150);
    chk("R8 nothing sent", {6'b0, txd, tx_end}, 8'h03);
    done();
  end
endmodule